// File: doc/BRIEF.md
# Set/Clear Control Register Bank

This block is a small memory-mapped bank of control registers that drives clock-gate, reset, isolation and general control lines for a neighbouring subsystem. A single-cycle request bus carries a valid strobe, a write flag, a byte address and a write word. Read data returns on a registered output one cycle after the read request.

Most of the state cannot be overwritten directly. The clock-gate and reset vectors each have a pair of addresses: one sets every bit written as 1, the other clears every bit written as 1. The isolation vector has only a clear address. A peripheral control register uses a half-word mask: the upper half of the written word selects which bits of the lower half are loaded. One plain control word is overwritten on write and read back unchanged. Software uses the paired addresses so that it never has to read, modify and write shared state.

Top module: `setclr_ctrl_bank`

## Requirements
- R1: After reset, every clock gate is off (`gate_en` = 0), every reset is asserted (`rst_on` all ones), isolation is on (`iso_on` all ones), `periph_ctrl` and `misc_ctrl` are 0, and `rsp_rdata` is 0.
- R2: A write at offset 0x040 sets every `gate_en` bit whose write-data bit is 1. Bits written as 0 keep their value. Bit 0 gates the reference clock and bit 1 gates the bus clock.
- R3: A write at offset 0x044 clears every `gate_en` bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A write at offset 0x090 asserts every `rst_on` bit written as 1, and a write at offset 0x094 deasserts every bit written as 1. Bit 3 is the PHY power-on reset and bit 5 is the controller reset.
- R5: A write at offset 0x010 updates `periph_ctrl[i]` with write-data bit i only where write-data bit i+16 is 1. A mask bit of 1 with a data bit of 0 clears the bit. Data bits under a 0 mask bit have no effect. Bit 1 enables the crystal oscillator.
- R6: A write at offset 0x148 clears every `iso_on` bit written as 1. Bit 25 is the reference-clock isolation. No bus access can set an isolation bit again.
- R7: A write at offset 0x000 replaces `misc_ctrl` with the write word.
- R8: A read places data on `rsp_rdata` at the clock edge that takes the request. Both addresses of a set/clear pair return that vector zero-extended, 0x148 returns `iso_on`, and 0x010 returns `periph_ctrl` with bits 31:16 equal to 0.
- R9: A write to any other address leaves every output unchanged, and a read from any other address returns 0. Addresses are decoded in full.
- R10: A read request changes no control output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one transfer per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write word |
| rsp_rdata | output | DATA_W | Registered read data |
| gate_en | output | GATE_W | Clock-gate enables |
| rst_on | output | RST_W | Reset lines, 1 = asserted |
| iso_on | output | ISO_W | Isolation enables |
| periph_ctrl | output | DATA_W/2 | Masked-write peripheral controls |
| misc_ctrl | output | DATA_W | Plain control word |

## Verification
The properties assume that `req_write`, `req_addr` and `req_wdata` carry known values in every cycle where `req_valid` is high. They also assume that `req_write` has no effect while `req_valid` is low. The stimulus drives all request inputs on the falling edge from tasks and returns `req_valid` to 0 between transfers. It sweeps full patterns through each set/clear pair and the masked register, and it aims at addresses next to the mapped offsets. Every write and every read is followed by a comparison of all outputs against a model held in the bench.

// File: rtl/scb_pkg.sv
package scb_pkg;

    localparam logic [31:0] OFS_MISC     = 32'h000;
    localparam logic [31:0] OFS_PERIPH   = 32'h010;
    localparam logic [31:0] OFS_GATE_SET = 32'h040;
    localparam logic [31:0] OFS_GATE_CLR = 32'h044;
    localparam logic [31:0] OFS_RST_SET  = 32'h090;
    localparam logic [31:0] OFS_RST_CLR  = 32'h094;
    localparam logic [31:0] OFS_ISO_OFF  = 32'h148;

    typedef struct packed {
        logic misc;
        logic periph;
        logic gate_set;
        logic gate_clr;
        logic rst_set;
        logic rst_clr;
        logic iso_off;
    } sel_t;

    function automatic sel_t decode(input logic [31:0] addr);
        sel_t s;
        s.misc     = (addr == OFS_MISC);
        s.periph   = (addr == OFS_PERIPH);
        s.gate_set = (addr == OFS_GATE_SET);
        s.gate_clr = (addr == OFS_GATE_CLR);
        s.rst_set  = (addr == OFS_RST_SET);
        s.rst_clr  = (addr == OFS_RST_CLR);
        s.iso_off  = (addr == OFS_ISO_OFF);
        return s;
    endfunction

endpackage

// File: rtl/scb_setclr.sv
module scb_setclr #(
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] state
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_stb) state_d = state_d | bits;
        if (clr_stb) state_d = state_d & ~bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_VAL;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/scb_maskwr.sv
module scb_maskwr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] data,
    output logic [W-1:0] state
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_stb) state_d = (state_q & ~mask) | (data & mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/scb_rdmux.sv
module scb_rdmux #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned GATE_W = 8,
    parameter int unsigned RST_W  = 8,
    parameter int unsigned ISO_W  = 32,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  scb_pkg::sel_t      sel,
    input  logic [GATE_W-1:0]  gate,
    input  logic [RST_W-1:0]   rst,
    input  logic [ISO_W-1:0]   iso,
    input  logic [HALF_W-1:0]  periph,
    input  logic [DATA_W-1:0]  misc,
    output logic [DATA_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        if (sel.gate_set || sel.gate_clr) rdata[GATE_W-1:0] = gate;
        else if (sel.rst_set || sel.rst_clr) rdata[RST_W-1:0] = rst;
        else if (sel.iso_off) rdata[ISO_W-1:0] = iso;
        else if (sel.periph) rdata[HALF_W-1:0] = periph;
        else if (sel.misc) rdata = misc;
    end
endmodule

// File: rtl/setclr_ctrl_bank.sv
module setclr_ctrl_bank #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned GATE_W = 8,
    parameter int unsigned RST_W  = 8,
    parameter int unsigned ISO_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [GATE_W-1:0]   gate_en,
    output logic [RST_W-1:0]    rst_on,
    output logic [ISO_W-1:0]    iso_on,
    output logic [DATA_W/2-1:0] periph_ctrl,
    output logic [DATA_W-1:0]   misc_ctrl
);
    import scb_pkg::*;

    localparam int unsigned HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] misc;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [31:0]       addr_ext;
    sel_t              sel;
    logic              wr, rd;
    logic [DATA_W-1:0] mux_data;

    assign addr_ext = {{(32-ADDR_W){1'b0}}, req_addr};
    assign sel      = decode(addr_ext);
    assign wr       = req_valid &  req_write;
    assign rd       = req_valid & ~req_write;

    scb_setclr #(.W(GATE_W), .RST_VAL('0)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .set_stb(wr & sel.gate_set), .clr_stb(wr & sel.gate_clr),
        .bits(req_wdata[GATE_W-1:0]), .state(gate_en)
    );

    scb_setclr #(.W(RST_W), .RST_VAL({RST_W{1'b1}})) u_rst (
        .clk(clk), .rst_n(rst_n),
        .set_stb(wr & sel.rst_set), .clr_stb(wr & sel.rst_clr),
        .bits(req_wdata[RST_W-1:0]), .state(rst_on)
    );

    scb_setclr #(.W(ISO_W), .RST_VAL({ISO_W{1'b1}})) u_iso (
        .clk(clk), .rst_n(rst_n),
        .set_stb(1'b0), .clr_stb(wr & sel.iso_off),
        .bits(req_wdata[ISO_W-1:0]), .state(iso_on)
    );

    scb_maskwr #(.W(HALF_W)) u_periph (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr & sel.periph),
        .mask(req_wdata[DATA_W-1:HALF_W]), .data(req_wdata[HALF_W-1:0]),
        .state(periph_ctrl)
    );

    scb_rdmux #(.DATA_W(DATA_W), .GATE_W(GATE_W), .RST_W(RST_W), .ISO_W(ISO_W)) u_rdmux (
        .sel(sel), .gate(gate_en), .rst(rst_on), .iso(iso_on),
        .periph(periph_ctrl), .misc(r_q.misc), .rdata(mux_data)
    );

    always_comb begin
        r_d = r_q;
        if (wr && sel.misc) r_d.misc  = req_wdata;
        if (rd)             r_d.rdata = mux_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign misc_ctrl = r_q.misc;
    assign rsp_rdata = r_q.rdata;
endmodule

// File: rtl/scb_chk.sv
module scb_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned GATE_W = 8,
    parameter int unsigned RST_W  = 8,
    parameter int unsigned ISO_W  = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DATA_W-1:0]   req_wdata,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic [GATE_W-1:0]   gate_en,
    input logic [RST_W-1:0]    rst_on,
    input logic [ISO_W-1:0]    iso_on,
    input logic [DATA_W/2-1:0] periph_ctrl,
    input logic [DATA_W-1:0]   misc_ctrl
);
    import scb_pkg::*;

    localparam int unsigned HALF_W = DATA_W / 2;

    sel_t c_sel;
    logic c_wr, c_rd, c_mapped;

    assign c_sel    = decode({{(32-ADDR_W){1'b0}}, req_addr});
    assign c_wr     = req_valid &  req_write;
    assign c_rd     = req_valid & ~req_write;
    assign c_mapped = |c_sel;

    p_gate_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && c_sel.gate_set |=> gate_en == ($past(gate_en) | $past(req_wdata[GATE_W-1:0])))
        else $error("gate set");

    p_gate_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && c_sel.gate_clr |=> gate_en == ($past(gate_en) & ~$past(req_wdata[GATE_W-1:0])))
        else $error("gate clear");

    p_rst_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && c_sel.rst_set |=> rst_on == ($past(rst_on) | $past(req_wdata[RST_W-1:0])))
        else $error("reset assert");

    p_rst_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && c_sel.rst_clr |=> rst_on == ($past(rst_on) & ~$past(req_wdata[RST_W-1:0])))
        else $error("reset deassert");

    p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && c_sel.periph |=>
            ((periph_ctrl ^ $past(periph_ctrl)) & ~$past(req_wdata[DATA_W-1:HALF_W])) == '0)
        else $error("masked bit changed");

    p_mask_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && c_sel.periph |=>
            ((periph_ctrl ^ $past(req_wdata[HALF_W-1:0])) & $past(req_wdata[DATA_W-1:HALF_W])) == '0)
        else $error("enabled bit not loaded");

    p_iso_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid || !req_valid |=> (iso_on & ~$past(iso_on)) == '0)
        else $error("isolation bit rose");

    p_misc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && c_sel.misc |=> misc_ctrl == $past(req_wdata))
        else $error("plain register");

    p_periph_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd && c_sel.periph |=> rsp_rdata[DATA_W-1:HALF_W] == '0)
        else $error("masked read upper half");

    p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && !c_mapped |=> $stable(gate_en) && $stable(rst_on) && $stable(iso_on)
                              && $stable(periph_ctrl) && $stable(misc_ctrl))
        else $error("unmapped write changed state");

    p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd && !c_mapped |=> rsp_rdata == '0)
        else $error("unmapped read nonzero");

    p_read_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd |=> $stable(gate_en) && $stable(rst_on) && $stable(iso_on)
                 && $stable(periph_ctrl) && $stable(misc_ctrl))
        else $error("read changed state");
endmodule

bind setclr_ctrl_bank scb_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GATE_W(GATE_W), .RST_W(RST_W), .ISO_W(ISO_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .gate_en(gate_en), .rst_on(rst_on), .iso_on(iso_on),
    .periph_ctrl(periph_ctrl), .misc_ctrl(misc_ctrl)
);

// File: tb/setclr_ctrl_bank_tb_top.sv
module setclr_ctrl_bank_tb_top;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned GATE_W = 8;
    localparam int unsigned RST_W  = 8;
    localparam int unsigned ISO_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] rsp_rdata;
    logic [GATE_W-1:0] gate_en;
    logic [RST_W-1:0]  rst_on;
    logic [ISO_W-1:0]  iso_on;
    logic [DATA_W/2-1:0] periph_ctrl;
    logic [DATA_W-1:0] misc_ctrl;

    int tests = 0;
    int fails = 0;

    logic [31:0] m_gate, m_rst, m_iso, m_per, m_misc;

    always #4 clk = ~clk;

    setclr_ctrl_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GATE_W(GATE_W),
                       .RST_W(RST_W), .ISO_W(ISO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .gate_en(gate_en), .rst_on(rst_on), .iso_on(iso_on),
        .periph_ctrl(periph_ctrl), .misc_ctrl(misc_ctrl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag);
        chk({tag, " gate_en"},     32'(gate_en),     m_gate);
        chk({tag, " rst_on"},      32'(rst_on),      m_rst);
        chk({tag, " iso_on"},      32'(iso_on),      m_iso);
        chk({tag, " periph_ctrl"}, 32'(periph_ctrl), m_per);
        chk({tag, " misc_ctrl"},   misc_ctrl,        m_misc);
    endtask

    // Model of the requirements: next state after a write
    task automatic model_wr(input logic [31:0] a, input logic [31:0] d);
        case (a)
            32'h040: m_gate = (m_gate | d) & 32'hFF;
            32'h044: m_gate = m_gate & ~d;
            32'h090: m_rst  = (m_rst | d) & 32'hFF;
            32'h094: m_rst  = m_rst & ~d;
            32'h010: m_per  = (m_per & ~(d >> 16)) | (d & (d >> 16) & 32'hFFFF);
            32'h148: m_iso  = m_iso & ~d;
            32'h000: m_misc = d;
            default: ;
        endcase
    endtask

    function automatic logic [31:0] model_rd(input logic [31:0] a);
        case (a)
            32'h040, 32'h044: return m_gate;
            32'h090, 32'h094: return m_rst;
            32'h148:          return m_iso;
            32'h010:          return m_per;
            32'h000:          return m_misc;
            default:          return 32'h0;
        endcase
    endfunction

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = a[ADDR_W-1:0]; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model_wr(a, d);
        chk_outs(tag);
    endtask

    task automatic rd(input logic [31:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = a[ADDR_W-1:0]; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " rsp_rdata"}, rsp_rdata, model_rd(a));
        chk_outs({tag, " after read"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_gate = 32'h0; m_rst = 32'hFF; m_iso = 32'hFFFF_FFFF; m_per = 32'h0; m_misc = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_outs("R1 reset");
        chk("R1 rsp_rdata", rsp_rdata, 32'h0);

        // R2 / R3: walking bits, then a full sweep of set patterns with interleaved clears
        for (int i = 0; i < GATE_W; i++) begin
            wr(32'h040, 32'h1 << i, "R2 walk set");
            rd(32'h044, "R8 gate via clear addr");
        end
        for (int i = 0; i < GATE_W; i++) wr(32'h044, 32'h1 << i, "R3 walk clear");
        wr(32'h040, 32'h3, "R2 ref and bus clock gates");
        chk("R2 bit0/bit1", 32'(gate_en), 32'h3);
        for (int i = 0; i < 256; i++) begin
            wr(32'h040, 32'(i) | 32'hFFFF_FF00, "R2 sweep set");
            wr(32'h044, 32'((i * 73 + 11) & 255), "R3 sweep clear");
        end
        rd(32'h040, "R8 gate via set addr");

        // R4: reset set/clear
        wr(32'h094, 32'h28, "R4 deassert PHY POR and controller");
        chk("R4 bits 3 and 5 low", 32'(rst_on) & 32'h28, 32'h0);
        wr(32'h090, 32'h08, "R4 assert PHY POR only");
        chk("R4 bit3 high", 32'(rst_on) & 32'h28, 32'h08);
        for (int i = 0; i < 256; i++) begin
            wr(32'h094, 32'(i), "R4 sweep deassert");
            wr(32'h090, 32'((i * 37 + 5) & 255), "R4 sweep assert");
        end
        rd(32'h090, "R8 reset via set addr");
        rd(32'h094, "R8 reset via clear addr");

        // R5: masked write
        wr(32'h010, 32'h0002_0002, "R5 oscillator enable");
        chk("R5 bit1 set", 32'(periph_ctrl), 32'h2);
        wr(32'h010, 32'h0000_FFFF, "R5 data without mask ignored");
        chk("R5 unchanged", 32'(periph_ctrl), 32'h2);
        wr(32'h010, 32'h0002_0000, "R5 mask with zero data clears");
        chk("R5 bit1 cleared", 32'(periph_ctrl), 32'h0);
        for (int i = 0; i < 256; i++)
            wr(32'h010, ((32'(i) * 32'h9E37) << 16) | ((32'(i) * 32'h79B9) ^ 32'h3C5A), "R5 sweep");
        rd(32'h010, "R8 masked read upper zero");

        // R6: isolation clear only
        wr(32'h148, 32'h0, "R6 zero write no effect");
        wr(32'h148, 32'h0200_0000, "R6 refclk isolation off");
        chk("R6 bit25 low", 32'(iso_on), 32'hFDFF_FFFF);
        wr(32'h148, 32'h0000_00F0, "R6 more bits off");
        rd(32'h148, "R8 iso read");

        // R7: plain register
        wr(32'h000, 32'hA5A5_5A5A, "R7 load");
        wr(32'h000, 32'h1234_5678, "R7 reload");
        rd(32'h000, "R8 misc read");

        // R9: unmapped addresses
        wr(32'h004, 32'hFFFF_FFFF, "R9 write 0x004");
        wr(32'h042, 32'hFFFF_FFFF, "R9 write 0x042");
        wr(32'h048, 32'hFFFF_FFFF, "R9 write 0x048");
        wr(32'h14C, 32'hFFFF_FFFF, "R9 write 0x14C");
        wr(32'hFFC, 32'hFFFF_FFFF, "R9 write 0xFFC");
        rd(32'h004, "R9 read 0x004");
        rd(32'h092, "R9 read 0x092");
        rd(32'hFFC, "R9 read 0xFFC");

        // R10: reads of every mapped address leave outputs alone
        rd(32'h040, "R10 read gate");
        rd(32'h094, "R10 read reset");
        rd(32'h010, "R10 read periph");
        rd(32'h148, "R10 read iso");
        rd(32'h000, "R10 read misc");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule